// File: doc/BRIEF.md
# Sensor Core-Access Sequencer

This block is the host-side controller for an on-chip analog sensor front end driven directly from logic. A one-cycle start request latches an 8-bit configuration word and a 16-bit channel enable mask. The block then enables the sensor's direct-access mode. It releases the sensor from reset after a fixed wait and, after a second wait, holds a configuration strobe high for eight cycles. During that strobe it shifts the configuration word out serially.

When the strobe drops, the sensor begins its first conversion. From then on the block keeps the channel select one step ahead of the conversion in progress. The next enabled channel is on the select lines while the current one converts. Each result is captured when the sensor's end-of-conversion flag falls. It is presented as a one-cycle valid pulse carrying the 6-bit value, the channel that produced it, and a flag saying the sensor reported end of sequence. The scan runs in ascending channel order and wraps around without end until the synchronous abort input returns the block to idle.

Top module: `vsense_seq`

## Requirements
- R1: Out of reset the block is idle with the mode output low, the sensor reset output high, the strobe low and no valid result. A start request raises the mode output on the following cycle.
- R2: The sensor reset output falls exactly 2 cycles after the mode output rises. The configuration strobe rises exactly 2 cycles after that.
- R3: The configuration strobe stays high for exactly 8 consecutive cycles. The serial data output carries the configuration word during those cycles, bit 7 first and bit 0 last, one bit per cycle.
- R4: While the strobe is high, the channel select output holds the lowest-numbered enabled channel and does not change.
- R5: The channel select runs one conversion ahead. After the strobe falls it moves to the enabled channel that follows the one being converted. After each captured result it moves on again, so that in the cycle of each valid pulse for channel c it shows the enabled channel two steps after c.
- R6: A result is taken when the end-of-conversion input goes from 1 to 0. In the next cycle the valid output is high for exactly one cycle, with the data input value from the falling-edge cycle and the channel number whose conversion ended.
- R7: Enabled channels are scanned in ascending order (mask bit n enables channel n) and wrap from the highest back to the lowest. A mask with one bit set repeats that channel. Only enabled channels ever appear on the result channel output.
- R8: The result's last flag is 1 exactly when the end-of-sequence input was high while end-of-conversion was high for that conversion.
- R9: With an all-zero mask the block completes the power-up and configuration steps and then stays parked. The mode output stays high, the strobe stays low, and no result is produced even if the sensor toggles end-of-conversion.
- R10: A synchronous abort returns the block to idle from any state. On the next cycle the mode output is low and the sensor reset output high, and no result follows until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled while idle |
| abort_i | input | 1 | Synchronous return to idle |
| cfg_word_i | input | 8 | Configuration word latched at start |
| ch_mask_i | input | 16 | Channel enable mask latched at start |
| sens_mode_o | output | 1 | Direct-access mode enable to the sensor |
| sens_rst_o | output | 1 | Sensor reset, active high |
| sens_cfg_o | output | 1 | Configuration strobe |
| sens_sdata_o | output | 1 | Serial configuration data |
| sens_chan_o | output | 4 | Channel select |
| sens_eoc_i | input | 1 | End of conversion from the sensor |
| sens_eos_i | input | 1 | End of sequence from the sensor |
| sens_data_i | input | 6 | Conversion result from the sensor |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 6 | Captured result |
| res_chan_o | output | 4 | Channel of the captured result |
| res_last_o | output | 1 | End-of-sequence seen for this result |

## Verification
The bench measures the gaps between mode rise, reset release and strobe edges cycle by cycle. A wait counter off by one shows up directly as a wrong gap, and a shifter that ran LSB-first or one cycle late shows up as a scrambled configuration word. Sparse, single-channel and full masks cover the wrap-around of the scan: a design that skipped channel 15, repeated the wrong channel or forgot to wrap would push the scoreboard out of order. The next-select check at every result catches a design that presents the current channel instead of staying one step ahead. An all-zero mask with a sensor stub that still toggles end-of-conversion catches a design that reports phantom results. Aborts issued while a conversion is in flight catch late results or a mode line that stays high.

// File: rtl/vsense_pkg.sv
package vsense_pkg;

    localparam int unsigned WAIT_DEF = 2;
    localparam int unsigned CFGB_DEF = 8;
    localparam int unsigned DATA_DEF = 6;
    localparam int unsigned CHW_DEF  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MODE,
        ST_RELEASE,
        ST_SHIFT,
        ST_RUN,
        ST_PARK
    } seq_state_e;

endpackage

// File: rtl/vsense_ctrl.sv
module vsense_ctrl
    import vsense_pkg::*;
#(
    parameter int unsigned WAIT_CYC = WAIT_DEF,
    parameter int unsigned CFG_BITS = CFGB_DEF,
    parameter int unsigned NCH      = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                abort_i,
    input  logic [CFG_BITS-1:0] word_i,
    input  logic [NCH-1:0]      mask_i,
    output logic [CFG_BITS-1:0] word_q,
    output logic [NCH-1:0]      mask_q,
    output logic                mode_o,
    output logic                srst_o,
    output logic                strobe_o,
    output logic                load_o,
    output logic                go_o,
    output logic                run_o
);
    localparam int unsigned LONGEST = (WAIT_CYC > CFG_BITS) ? WAIT_CYC : CFG_BITS;
    localparam int unsigned CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] CFG_LAST  = CNT_W'(CFG_BITS - 1);

    seq_state_e       st;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            word_q <= '0;
            mask_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start_i) begin
                        st     <= ST_MODE;
                        word_q <= word_i;
                        mask_q <= mask_i;
                    end
                end
                ST_MODE: begin
                    if (cnt == WAIT_LAST) begin
                        st  <= ST_RELEASE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RELEASE: begin
                    if (cnt == WAIT_LAST) begin
                        st  <= ST_SHIFT;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (cnt == CFG_LAST) begin
                        st  <= (mask_q != '0) ? ST_RUN : ST_PARK;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign mode_o   = (st != ST_IDLE);
    assign srst_o   = (st == ST_IDLE) || (st == ST_MODE);
    assign strobe_o = (st == ST_SHIFT);
    assign run_o    = (st == ST_RUN);
    assign load_o   = (st == ST_RELEASE) && (cnt == WAIT_LAST) && !abort_i;
    assign go_o     = (st == ST_SHIFT) && (cnt == CFG_LAST) && (mask_q != '0) && !abort_i;

    // R2: reset release only after mode has been up for the full wait
    a_r2_release_after_mode: assert property (@(posedge clk) disable iff (rst)
        $fell(srst_o) |-> mode_o && $past(mode_o));

    // R3: strobe window never outlasts the configuration width
    a_r3_strobe_window: assert property (@(posedge clk) disable iff (rst)
        strobe_o |-> (cnt <= CFG_LAST));

    // R10: abort drops mode and holds the sensor in reset on the next cycle
    a_r10_abort_idle: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> !mode_o && srst_o && !strobe_o);
endmodule

// File: rtl/vsense_shift.sv
module vsense_shift #(
    parameter int unsigned CFG_BITS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic                shift_i,
    input  logic [CFG_BITS-1:0] word_i,
    output logic                sdata_o
);
    logic [CFG_BITS-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (load_i) begin
            sh <= word_i;
        end else if (shift_i) begin
            sh <= {sh[CFG_BITS-2:0], 1'b0};
        end
    end

    assign sdata_o = shift_i ? sh[CFG_BITS-1] : 1'b0;
endmodule

// File: rtl/vsense_sched.sv
module vsense_sched #(
    parameter int unsigned CH_W   = 4,
    parameter int unsigned DATA_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     abort_i,
    input  logic                     load_i,
    input  logic                     go_i,
    input  logic                     run_i,
    input  logic [(1<<CH_W)-1:0]     mask_i,
    input  logic                     eoc_i,
    input  logic                     eos_i,
    input  logic [DATA_W-1:0]        data_i,
    output logic [CH_W-1:0]          chan_o,
    output logic                     res_valid_o,
    output logic [DATA_W-1:0]        res_data_o,
    output logic [CH_W-1:0]          res_chan_o,
    output logic                     res_last_o
);
    localparam int unsigned NCH = 1 << CH_W;

    function automatic logic [CH_W-1:0] next_en(input logic [NCH-1:0] m,
                                                 input logic [CH_W-1:0] c);
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] idx;
        logic            hit;
        r   = c;
        hit = 1'b0;
        for (int i = 1; i <= NCH; i++) begin
            idx = CH_W'(int'(c) + i);
            if (!hit && m[idx]) begin
                r   = idx;
                hit = 1'b1;
            end
        end
        return r;
    endfunction

    logic            eoc_q;
    logic            eos_seen;
    logic [CH_W-1:0] cur;
    logic            fall;

    assign fall = run_i && eoc_q && !eoc_i;

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            eoc_q       <= 1'b0;
            eos_seen    <= 1'b0;
            cur         <= '0;
            chan_o      <= '0;
            res_valid_o <= 1'b0;
            res_data_o  <= '0;
            res_chan_o  <= '0;
            res_last_o  <= 1'b0;
        end else begin
            eoc_q       <= eoc_i && run_i;
            res_valid_o <= 1'b0;
            if (run_i && eoc_i && eos_i) begin
                eos_seen <= 1'b1;
            end
            if (load_i) begin
                chan_o <= next_en(mask_i, '1);
            end
            if (go_i) begin
                cur    <= chan_o;
                chan_o <= next_en(mask_i, chan_o);
            end
            if (fall) begin
                res_valid_o <= 1'b1;
                res_data_o  <= data_i;
                res_chan_o  <= cur;
                res_last_o  <= eos_seen;
                eos_seen    <= 1'b0;
                cur         <= chan_o;
                chan_o      <= next_en(mask_i, chan_o);
            end
        end
    end

    // R6: a result strobe is never two cycles long
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |=> !res_valid_o);

    // R7: only enabled channels are reported
    a_r7_enabled_only: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> mask_i[res_chan_o]);

    // R9: outside the running state no result can follow
    a_r9_quiet_unless_run: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !res_valid_o);
endmodule

// File: rtl/vsense_seq.sv
module vsense_seq
    import vsense_pkg::*;
#(
    parameter int unsigned WAIT_CYC = WAIT_DEF,
    parameter int unsigned CFG_BITS = CFGB_DEF,
    parameter int unsigned DATA_W   = DATA_DEF,
    parameter int unsigned CH_W     = CHW_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic                  abort_i,
    input  logic [CFG_BITS-1:0]   cfg_word_i,
    input  logic [(1<<CH_W)-1:0]  ch_mask_i,
    output logic                  sens_mode_o,
    output logic                  sens_rst_o,
    output logic                  sens_cfg_o,
    output logic                  sens_sdata_o,
    output logic [CH_W-1:0]       sens_chan_o,
    input  logic                  sens_eoc_i,
    input  logic                  sens_eos_i,
    input  logic [DATA_W-1:0]     sens_data_i,
    output logic                  res_valid_o,
    output logic [DATA_W-1:0]     res_data_o,
    output logic [CH_W-1:0]       res_chan_o,
    output logic                  res_last_o
);
    localparam int unsigned NCH = 1 << CH_W;

    logic [CFG_BITS-1:0] word_q;
    logic [NCH-1:0]      mask_q;
    logic                load, go, run;

    vsense_ctrl #(
        .WAIT_CYC (WAIT_CYC),
        .CFG_BITS (CFG_BITS),
        .NCH      (NCH)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .abort_i  (abort_i),
        .word_i   (cfg_word_i),
        .mask_i   (ch_mask_i),
        .word_q   (word_q),
        .mask_q   (mask_q),
        .mode_o   (sens_mode_o),
        .srst_o   (sens_rst_o),
        .strobe_o (sens_cfg_o),
        .load_o   (load),
        .go_o     (go),
        .run_o    (run)
    );

    vsense_shift #(
        .CFG_BITS (CFG_BITS)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .shift_i (sens_cfg_o),
        .word_i  (word_q),
        .sdata_o (sens_sdata_o)
    );

    vsense_sched #(
        .CH_W   (CH_W),
        .DATA_W (DATA_W)
    ) u_sched (
        .clk         (clk),
        .rst         (rst),
        .abort_i     (abort_i),
        .load_i      (load),
        .go_i        (go),
        .run_i       (run),
        .mask_i      (mask_q),
        .eoc_i       (sens_eoc_i),
        .eos_i       (sens_eos_i),
        .data_i      (sens_data_i),
        .chan_o      (sens_chan_o),
        .res_valid_o (res_valid_o),
        .res_data_o  (res_data_o),
        .res_chan_o  (res_chan_o),
        .res_last_o  (res_last_o)
    );

    // R4: channel select holds still across the configuration strobe
    a_r4_chan_steady: assert property (@(posedge clk) disable iff (rst)
        sens_cfg_o && $past(sens_cfg_o) |-> $stable(sens_chan_o));
endmodule

// File: tb/tb_vsense_seq.sv
module tb_vsense_seq;
    localparam int CLK_P = 10;
    localparam int CONV  = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic [7:0]  word = '0;
    logic [15:0] mask = '0;
    logic        mode, srst, strobe, sdata;
    logic [3:0]  chan;
    logic        eoc = 1'b0, eos = 1'b0;
    logic [5:0]  sdat = '0;
    logic        rv, rl;
    logic [5:0]  rd;
    logic [3:0]  rc;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct { logic [3:0] ch; logic [5:0] d; logic last; } exp_t;
    exp_t exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    vsense_seq dut (
        .clk(clk), .rst(rst), .start_i(start), .abort_i(abort),
        .cfg_word_i(word), .ch_mask_i(mask),
        .sens_mode_o(mode), .sens_rst_o(srst), .sens_cfg_o(strobe),
        .sens_sdata_o(sdata), .sens_chan_o(chan),
        .sens_eoc_i(eoc), .sens_eos_i(eos), .sens_data_i(sdat),
        .res_valid_o(rv), .res_data_o(rd), .res_chan_o(rc), .res_last_o(rl)
    );

    function automatic logic [5:0] sens_val(input logic [3:0] c);
        return 6'(int'(c) * 5 + 3);
    endfunction

    function automatic logic [3:0] bnext(input logic [15:0] m, input logic [3:0] c);
        for (int i = 1; i <= 16; i++) begin
            if (m[(int'(c) + i) % 16]) return 4'((int'(c) + i) % 16);
        end
        return c;
    endfunction

    function automatic logic [3:0] top_ch(input logic [15:0] m);
        logic [3:0] t;
        t = '0;
        for (int i = 0; i < 16; i++) if (m[i]) t = 4'(i);
        return t;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural sensor stub
    logic       stb_q = 1'b0, busy = 1'b0;
    int         scnt = 0;
    logic [3:0] cch = '0, nch = '0, pend = '0;
    always @(posedge clk) begin
        stb_q <= strobe;
        if (srst) begin
            busy <= 1'b0; eoc <= 1'b0; eos <= 1'b0; scnt <= 0; stb_q <= 1'b0;
        end else begin
            if (strobe) pend <= chan;
            if (stb_q && !strobe) begin
                busy <= 1'b1; cch <= pend; scnt <= 0;
            end else if (busy) begin
                if (!eoc) begin
                    if (scnt == CONV-1) begin
                        eoc  <= 1'b1;
                        eos  <= (cch == top_ch(mask));
                        sdat <= sens_val(cch);
                        nch  <= chan;
                        scnt <= 0;
                    end else scnt <= scnt + 1;
                end else begin
                    if (scnt == 1) begin
                        eoc <= 1'b0; eos <= 1'b0; cch <= nch; scnt <= 0;
                    end else scnt <= scnt + 1;
                end
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && rv) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9/R10", "unexpected result chan", int'(rc), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rc == e.ch, "R7", "result channel", int'(rc), int'(e.ch));
                check(rd == e.d, "R6", "result data", int'(rd), int'(e.d));
                check(rl == e.last, "R8", "last flag", int'(rl), int'(e.last));
                check(chan == bnext(mask, bnext(mask, e.ch)), "R5", "select ahead",
                      int'(chan), int'(bnext(mask, bnext(mask, e.ch))));
            end
        end
    end

    task automatic do_abort();
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check(!mode && srst, "R10", "mode/reset after abort", int'({mode, srst}), 1);
        repeat (40) @(negedge clk);
        check(!mode && !rv, "R10", "stays idle", int'(mode), 0);
    endtask

    task automatic run_seq(input logic [7:0] w, input logic [15:0] m, input int n);
        int cyc, t_mode, t_rel, t_on, t_off, nb, guard;
        logic [7:0] bits;
        logic [3:0] c, first;
        bit chan_ok, pm, pr, ps;
        word = w; mask = m;
        first = bnext(m, 4'hF);
        c = first;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.ch = c; e.d = sens_val(c); e.last = (c == top_ch(m));
            exp_q.push_back(e);
            c = bnext(m, c);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; t_mode = -1; t_rel = -1; t_on = -1; t_off = -1; nb = 0;
        bits = '0; chan_ok = 1'b1; pm = 1'b0; pr = 1'b1; ps = 1'b0;
        check(mode == 1'b1, "R1", "mode after start", int'(mode), 1);
        guard = 0;
        while (t_off < 0 && guard < 100) begin
            if (mode && !pm) t_mode = cyc;
            if (!srst && pr) t_rel = cyc;
            if (strobe && !ps) t_on = cyc;
            if (!strobe && ps) t_off = cyc;
            if (strobe) begin
                bits = {bits[6:0], sdata};
                nb++;
                if (chan != first) chan_ok = 1'b0;
            end
            pm = mode; pr = srst; ps = strobe;
            @(negedge clk);
            cyc++; guard++;
        end
        check(t_rel - t_mode == 2, "R2", "mode to reset release", t_rel - t_mode, 2);
        check(t_on - t_rel == 2, "R2", "release to strobe", t_on - t_rel, 2);
        check(t_off - t_on == 8 && nb == 8, "R3", "strobe length", t_off - t_on, 8);
        check(bits == w, "R3", "serial word MSB first", int'(bits), int'(w));
        check(chan_ok, "R4", "select during strobe", int'(chan_ok), 1);
        if (m == '0) begin
            repeat (300) @(negedge clk);
            check(mode && !strobe, "R9", "parked with mode high", int'({mode, strobe}), 2);
        end else begin
            check(chan == bnext(m, first), "R5", "select after strobe",
                  int'(chan), int'(bnext(m, first)));
            guard = 0;
            while (exp_q.size() != 0 && guard < 20000) begin
                @(negedge clk);
                guard++;
            end
            check(exp_q.size() == 0, "R6", "results outstanding", exp_q.size(), 0);
        end
        do_abort();
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!mode && srst && !strobe && !rv, "R1", "reset state",
              int'({mode, srst, strobe, rv}), 4);
        run_seq(8'hB5, 16'hA012, 9);   // sparse mask, wraps twice (R7)
        run_seq(8'h3C, 16'h8000, 4);   // single channel repeats (R7, R8)
        run_seq(8'h81, 16'hFFFF, 18);  // every channel, wrap 15 -> 0
        run_seq(8'h5A, 16'h0000, 0);   // R9 zero mask parks
        run_seq(8'hE7, 16'h0006, 3);   // abort with a conversion in flight (R10)
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule